// File: doc/BRIEF.md
# Latched Priority Interrupt Request Unit

This unit takes a group of active-low interrupt request lines and latches every falling edge. Each line has a mask bit. The unit picks the highest-numbered pending request that is not masked and reports it to the processor through an active-low interrupt output, a request number and a valid flag. Priority is fixed and descending: line 7 wins over every other line and line 0 loses to every other line. A status byte shows every pending request, whether it is masked or not.

Software acts on the unit through single-cycle strobes. One strobe loads the mask register. One strobe writes two control bits, and each bit clears the latches or the masks when it is written as 0. A status-read strobe clears every latch. A service-acknowledge strobe clears only the latch of the request being serviced. A cascade input from an upstream unit can stop this unit from claiming a service cycle. Its own interrupt output keeps following its own unmasked requests while it is blocked.

Request lines go through a two-stage synchronizer before edge detection. A falling edge on a request line appears on the registered outputs four clock edges after it is driven. If a new edge arrives in the same cycle as a clear, the edge wins and the latch stays set.

Top module: `irq_prio_unit`

## Requirements
- R1: A falling edge on `req_n[i]` sets the pending latch of line i. The line shows in `status` and in the other outputs on the fourth rising clock edge after the edge is driven. A level held low does not set the latch a second time.
- R2: `win_id` is the highest-numbered pending, unmasked line. Line 7 has the highest priority and line 0 the lowest. `win_id` is 0 when no unmasked request is pending.
- R3: When `mask_wr` is 1, `mask_wdata` is loaded into the mask register, and bit i = 1 masks line i. A masked line still latches and shows in `status`, but it never drives `irq_n` low and is never reported through `win_id`.
- R4: `irq_n` is 0 while any unmasked request is pending. It returns to 1 once none remains.
- R5: `status` bit i is 1 for every pending line, masked or unmasked. A one-cycle `status_rd` pulse clears all pending latches.
- R6: A one-cycle `svc_ack` pulse clears only the latch of the line shown by `win_id` while `win_valid` is 1. No other latch changes.
- R7: On `ctrl_wr`, `ctrl_keep_pend` = 0 clears all pending latches and `ctrl_keep_mask` = 0 clears all mask bits. A bit written as 1 leaves its state unchanged. If `mask_wr` is 1 in the same cycle, the mask load wins.
- R8: While `cascade_n` is 0, `win_valid` is 0 and `svc_ack` clears nothing. `irq_n` still follows this unit's own unmasked pending requests. `cascade_n` cannot be masked.
- R9: A falling edge that reaches the latch in the same cycle as any clear (status read, service acknowledge or control clear) leaves that line's latch set.
- R10: While `rst` is 1 and after it, all latches and all mask bits are 0, `irq_n` = 1, `win_valid` = 0, `win_id` = 0 and `status` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_LINES | Active-low request lines; a falling edge is latched |
| cascade_n | input | 1 | Active-low block from an upstream unit; tie to 1 if unused |
| mask_wr | input | 1 | Loads the mask register |
| mask_wdata | input | NUM_LINES | Mask value; 1 masks a line |
| ctrl_wr | input | 1 | Writes the two control bits |
| ctrl_keep_pend | input | 1 | Written as 0: clear all latches |
| ctrl_keep_mask | input | 1 | Written as 0: clear all mask bits |
| status_rd | input | 1 | Status read; clears all latches |
| svc_ack | input | 1 | Service acknowledge; clears the serviced latch |
| irq_n | output | 1 | Active-low interrupt to the processor |
| win_id | output | ID_W | Number of the winning request |
| win_valid | output | 1 | This unit claims the service cycle |
| status | output | NUM_LINES | Pending requests, masked or unmasked |

## Verification
The hardest case to reach from the ports is the race of R9. A synchronized falling edge has to reach the pending latch in exactly the same cycle as a status-read clear. The bench gets there by counting edges. It drives a request low at a falling clock edge, waits two more falling edges, and then raises `status_rd` for one cycle. At that point a different line is already pending. The status byte must then show only the new line. The bench also walks a masked line through a service sequence and holds `cascade_n` low while it acknowledges. This shows that blocking suppresses the claim and the clear but leaves `irq_n` low.

// File: rtl/irqpu_pkg.sv
package irqpu_pkg;
  parameter int unsigned IRQPU_LINES  = 8;
  parameter int unsigned IRQPU_STAGES = 2;

  typedef struct packed {
    logic all_pend;
    logic all_mask;
  } irqpu_clr_t;
endpackage

// File: rtl/irqpu_sync.sv
module irqpu_sync #(
  parameter int unsigned NUM_LINES   = irqpu_pkg::IRQPU_LINES,
  parameter int unsigned SYNC_STAGES = irqpu_pkg::IRQPU_STAGES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_n,
  output logic [NUM_LINES-1:0] fall
);
  logic [NUM_LINES-1:0] stg [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '1;
      prev <= '1;
    end else begin
      stg[0] <= req_n;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[SYNC_STAGES-1];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_fall
    assign fall[i] = prev[i] & ~stg[SYNC_STAGES-1][i];
  end
endmodule

// File: rtl/irqpu_latch.sv
module irqpu_latch
  import irqpu_pkg::*;
#(
  parameter int unsigned NUM_LINES = IRQPU_LINES,
  localparam int unsigned ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] fall,
  input  irqpu_clr_t           clr,
  input  logic                 mask_wr,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic                 svc_en,
  input  logic [ID_W-1:0]      svc_id,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] mask
);
  logic [NUM_LINES-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr.all_pend) clr_vec = '1;
    else if (svc_en) clr_vec[svc_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      mask    <= '0;
    end else begin
      pending <= (pending & ~clr_vec) | fall;
      if (mask_wr)           mask <= mask_wdata;
      else if (clr.all_mask) mask <= '0;
    end
  end

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (|fall) |=> ((pending & $past(fall)) == $past(fall))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr.all_pend && !(|fall)) |=> (pending == '0)); // R5
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (svc_en && !clr.all_pend) |=>
      ($countones($past(pending) & ~pending) <= 1)); // R6
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr.all_mask && !mask_wr) |=> (mask == '0)); // R7
endmodule

// File: rtl/irqpu_prio.sv
module irqpu_prio
  import irqpu_pkg::*;
#(
  parameter int unsigned NUM_LINES = IRQPU_LINES,
  localparam int unsigned ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pending,
  input  logic [NUM_LINES-1:0] mask,
  input  logic                 cascade_n,
  output logic                 irq_n,
  output logic [ID_W-1:0]      win_id,
  output logic                 win_valid,
  output logic [NUM_LINES-1:0] status
);
  logic [NUM_LINES-1:0] live;
  logic [ID_W-1:0]      top_id;

  assign live = pending & ~mask;

  always_comb begin
    top_id = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (live[i]) top_id = ID_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n     <= 1'b1;
      win_id    <= '0;
      win_valid <= 1'b0;
      status    <= '0;
    end else begin
      irq_n     <= ~(|live);
      win_id    <= top_id;
      win_valid <= (|live) & cascade_n;
      status    <= pending;
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (live == '0) |=> irq_n); // R3
  AST_CASCADE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    !cascade_n |=> !win_valid); // R8
  AST_VALID_IRQ: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !irq_n); // R4
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irqpu_pkg::*;
#(
  parameter int unsigned NUM_LINES   = IRQPU_LINES,
  parameter int unsigned SYNC_STAGES = IRQPU_STAGES,
  localparam int unsigned ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_n,
  input  logic                 cascade_n,
  input  logic                 mask_wr,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic                 ctrl_wr,
  input  logic                 ctrl_keep_pend,
  input  logic                 ctrl_keep_mask,
  input  logic                 status_rd,
  input  logic                 svc_ack,
  output logic                 irq_n,
  output logic [ID_W-1:0]      win_id,
  output logic                 win_valid,
  output logic [NUM_LINES-1:0] status
);
  logic [NUM_LINES-1:0] fall;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] mask;
  irqpu_clr_t           clr;
  logic                 svc_en;

  assign clr.all_pend = status_rd | (ctrl_wr & ~ctrl_keep_pend);
  assign clr.all_mask = ctrl_wr & ~ctrl_keep_mask;
  assign svc_en       = svc_ack & win_valid;

  irqpu_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_n(req_n), .fall(fall)
  );

  irqpu_latch #(.NUM_LINES(NUM_LINES)) u_latch (
    .clk(clk), .rst(rst), .fall(fall), .clr(clr),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .svc_en(svc_en), .svc_id(win_id),
    .pending(pending), .mask(mask)
  );

  irqpu_prio #(.NUM_LINES(NUM_LINES)) u_prio (
    .clk(clk), .rst(rst), .pending(pending), .mask(mask),
    .cascade_n(cascade_n), .irq_n(irq_n), .win_id(win_id),
    .win_valid(win_valid), .status(status)
  );

  AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!win_valid && !clr.all_pend) |=>
      ((pending & $past(pending)) == $past(pending))); // R8
  AST_KEEP_BITS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_keep_mask && !mask_wr) |=> $stable(mask)); // R7
endmodule

// File: tb/irq_prio_unit_tb.sv
module irq_prio_unit_tb;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] req_n = '1;
  logic          cascade_n = 1'b1;
  logic          mask_wr = 1'b0;
  logic [NL-1:0] mask_wdata = '0;
  logic          ctrl_wr = 1'b0;
  logic          ctrl_keep_pend = 1'b1;
  logic          ctrl_keep_mask = 1'b1;
  logic          status_rd = 1'b0;
  logic          svc_ack = 1'b0;
  logic          irq_n;
  logic [2:0]    win_id;
  logic          win_valid;
  logic [NL-1:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       irq_n;
    logic       valid;
    logic [2:0] id;
    logic [7:0] st;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  irq_prio_unit u_dut (
    .clk(clk), .rst(rst), .req_n(req_n), .cascade_n(cascade_n),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ctrl_wr(ctrl_wr),
    .ctrl_keep_pend(ctrl_keep_pend), .ctrl_keep_mask(ctrl_keep_mask),
    .status_rd(status_rd), .svc_ack(svc_ack), .irq_n(irq_n),
    .win_id(win_id), .win_valid(win_valid), .status(status)
  );

  // monitor: pops expectations and compares at falling edges
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (irq_n !== e.irq_n || win_valid !== e.valid ||
          status !== e.st || (e.valid && win_id !== e.id)) begin
        errors++;
        $display("FAIL %s: got irq_n=%b valid=%b id=%0d status=%h, exp irq_n=%b valid=%b id=%0d status=%h",
                 e.tag, irq_n, win_valid, win_id, status,
                 e.irq_n, e.valid, e.id, e.st);
      end
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic expect_out(input logic ei, input logic ev, input logic [2:0] eid,
                            input logic [7:0] est, input string tag);
    exp_t e;
    e.irq_n = ei; e.valid = ev; e.id = eid; e.st = est; e.tag = tag;
    sb.push_back(e);
    wait_n(2);
  endtask

  task automatic pulse_line(input int i);
    req_n[i] = 1'b0;
    wait_n(3);
    req_n[i] = 1'b1;
    wait_n(3);
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1;
    wait_n(1);
    s = 1'b0;
    wait_n(2);
  endtask

  task automatic ctrl_write(input logic kp, input logic km);
    ctrl_keep_pend = kp; ctrl_keep_mask = km; ctrl_wr = 1'b1;
    wait_n(1);
    ctrl_wr = 1'b0; ctrl_keep_pend = 1'b1; ctrl_keep_mask = 1'b1;
    wait_n(2);
  endtask

  task automatic mask_write(input logic [7:0] m);
    mask_wdata = m; mask_wr = 1'b1;
    wait_n(1);
    mask_wr = 1'b0;
    wait_n(2);
  endtask

  initial begin
    wait_n(3);
    expect_out(1'b1, 1'b0, 3'd0, 8'h00, "R10 reset state");
    rst = 1'b0;
    wait_n(2);
    expect_out(1'b1, 1'b0, 3'd0, 8'h00, "R10 idle after reset");

    // R1 latency: output appears on the fourth rising edge after drive
    req_n[3] = 1'b0;
    wait_n(3);
    expect_out(1'b1, 1'b0, 3'd0, 8'h00, "R1 not yet visible after three edges");
    expect_out(1'b0, 1'b1, 3'd3, 8'h08, "R1 R4 line 3 latched");
    req_n[3] = 1'b1;
    wait_n(3);

    pulse_line(6);
    expect_out(1'b0, 1'b1, 3'd6, 8'h48, "R2 line 6 outranks line 3");

    mask_write(8'h80);
    pulse_line(7);
    expect_out(1'b0, 1'b1, 3'd6, 8'hC8, "R3 masked line 7 in status only");

    strobe(svc_ack);
    expect_out(1'b0, 1'b1, 3'd3, 8'h88, "R6 ack clears only line 6");
    strobe(svc_ack);
    expect_out(1'b1, 1'b0, 3'd0, 8'h80, "R4 R3 only masked line remains");

    strobe(status_rd);
    expect_out(1'b1, 1'b0, 3'd0, 8'h00, "R5 status read clears all");

    pulse_line(1);
    ctrl_write(1'b1, 1'b1);
    pulse_line(7);
    expect_out(1'b0, 1'b1, 3'd1, 8'h82, "R7 keep bits leave latches and mask");

    ctrl_write(1'b1, 1'b0);
    expect_out(1'b0, 1'b1, 3'd7, 8'h82, "R7 mask cleared, line 7 wins");

    cascade_n = 1'b0;
    wait_n(2);
    expect_out(1'b0, 1'b0, 3'd7, 8'h82, "R8 cascade blocks claim, irq stays low");
    strobe(svc_ack);
    expect_out(1'b0, 1'b0, 3'd7, 8'h82, "R8 ack while blocked clears nothing");
    cascade_n = 1'b1;
    wait_n(2);

    ctrl_write(1'b0, 1'b1);
    expect_out(1'b1, 1'b0, 3'd0, 8'h00, "R7 control clears latches");

    // R9 race: line 5 edge reaches the latch in the status-read cycle
    pulse_line(2);
    req_n[5] = 1'b0;
    wait_n(2);
    status_rd = 1'b1;
    wait_n(1);
    status_rd = 1'b0;
    wait_n(2);
    expect_out(1'b0, 1'b1, 3'd5, 8'h20, "R9 new edge survives status clear");
    req_n[5] = 1'b1;
    wait_n(3);

    // R1 held-low level does not relatch after a clear
    req_n[4] = 1'b0;
    wait_n(5);
    strobe(status_rd);
    wait_n(3);
    expect_out(1'b1, 1'b0, 3'd0, 8'h00, "R1 held level not relatched");
    req_n[4] = 1'b1;
    wait_n(3);

    mask_write(8'hFF);
    pulse_line(0);
    expect_out(1'b1, 1'b0, 3'd0, 8'h01, "R3 all masked, line 0 in status");

    wait_n(3);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule